// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog for a processor subsystem. Its free-running counter is checked against two thresholds. Each threshold is a power of two, and software picks each one on its own. When the count reaches the lower-tier threshold, the block latches a pending flag and can raise an interrupt line. When the count reaches the upper-tier threshold, the block emits a one-cycle request that asks the system to reset. Software keeps the watchdog quiet by feeding it. A feed is two writes to the feed register: a key byte, then its complement key byte. Only that pair restarts the count, so a single stray store cannot do it.

The block has a small register port: address, write enable, write data and registered read data. Offset 0x0 holds the control word. It carries the two period codes, the enables, the pending flag and a sticky flag that records a reset request. Offset 0x4 is the feed register. The parameter `EXP_SHIFT` lowers every timeout exponent by the same amount and keeps the order of the codes. This keeps timeouts short in simulation.

Top module: `wdog_two_stage`

## Requirements
- R1: After the synchronous reset, the control word at offset 0x0 reads 0x00000000, and `irq_o` and `rst_req_o` are low.
- R2: Control bits [3:0] hold the interrupt period code n, which selects a timeout of T = 2^(31-n-EXP_SHIFT) cycles. If the watchdog and interrupt were enabled by the write at edge E, the pending flag (bit 9) and `irq_o` are still low after edge E+T and rise at edge E+T+1.
- R3: Control bits [7:4] hold the reset period code, with the same encoding. Its timeout Tr is separate from the interrupt period. With bit 11 set, `rst_req_o` is high for exactly one cycle, at edge E+Tr+1. It fires once per feed interval.
- R4: Control bit 8 enables the watchdog. While the bit is 0, the counter stays at zero and neither the pending flag nor the reset flag is set.
- R5: Control bit 10 enables the interrupt. The pending flag is set only while bit 10 is 1. `irq_o` equals the pending flag AND bit 10.
- R6: Writing 0 to bit 9 clears the pending flag. Writing 1 to bit 9 has no effect. A flag that has been cleared does not set again until the counter restarts.
- R7: Bit 31 sets when a reset request is issued. Only writing 0 to bit 31 or the block reset clears it, and writing 1 has no effect. When bit 11 is 0, no request is issued and bit 31 stays 0.
- R8: Writing 0xA5 and then 0x5A, both in bits [7:0] of the feed register at offset 0x4, clears the counter at the second write. The timeouts then count again from that edge.
- R9: A feed write with any other value abandons a partly written sequence. A write of 0xA5 always starts the sequence again, so A5, A5, 5A is a valid feed.
- R10: The read data is registered and appears one edge after the address. Offset 0x0 returns the control word, and every other offset, including 0x4, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt line (pending AND enabled) |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The timeout path is tested with several period codes. Adjacent codes show whether the exponent is decoded correctly, and the interrupt and reset periods are set to different codes, so a swap of the two fields is caught. Each threshold is sampled one cycle before and one cycle after it is reached, which catches any off-by-one in the counter or the flag. The feed port receives a clean A5/5A pair, a pair broken by a foreign byte, and a repeated A5 followed by 5A. The resulting firing times show whether the sequence was accepted, dropped or restarted.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W = 32;

  localparam int INT_CODE_LSB = 0;
  localparam int RST_CODE_LSB = 4;
  localparam int EN_BIT       = 8;
  localparam int PEND_BIT     = 9;
  localparam int IEN_BIT      = 10;
  localparam int REN_BIT      = 11;
  localparam int FLAG_BIT     = 31;

  localparam logic [7:0] FEED_KEY0 = 8'hA5;
  localparam logic [7:0] FEED_KEY1 = 8'h5A;

  typedef struct packed {
    logic       rst_flag;
    logic       rst_en;
    logic       int_en;
    logic       int_pend;
    logic       wd_en;
    logic [3:0] rst_code;
    logic [3:0] int_code;
  } wdog_ctrl_t;

  function automatic logic [REG_W-1:0] ctrl_to_word(wdog_ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[INT_CODE_LSB +: 4] = c.int_code;
    w[RST_CODE_LSB +: 4] = c.rst_code;
    w[EN_BIT]            = c.wd_en;
    w[PEND_BIT]          = c.int_pend;
    w[IEN_BIT]           = c.int_en;
    w[REN_BIT]           = c.rst_en;
    w[FLAG_BIT]          = c.rst_flag;
    return w;
  endfunction
endpackage

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  output logic       feed_o
);
  import wdog_pkg::*;

  logic armed_q;

  always_comb begin
    feed_o = wr_en && armed_q && (wr_byte == FEED_KEY1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (wr_en) begin
      armed_q <= (wr_byte == FEED_KEY0);
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run && (cnt_q != {CNT_W{1'b1}})) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_limit_cmp.sv
module wdog_limit_cmp #(
  parameter int CNT_W     = 32,
  parameter int EXP_SHIFT = 0
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [3:0]       code,
  output logic             reached
);
  logic [CNT_W:0] limit;
  int             expo;

  always_comb begin
    expo = 31 - int'(code) - EXP_SHIFT;
    if (expo < 0) expo = 0;
    limit = {{CNT_W{1'b0}}, 1'b1} << expo;
    reached = ({1'b0, cnt} >= limit);
  end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int ADDR_W    = 4,
  parameter int EXP_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  import wdog_pkg::*;

  localparam int CNT_W   = 32 - EXP_SHIFT;
  localparam int N_STAGE = 2;
  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] FEED_OFF = ADDR_W'(4);

  wdog_ctrl_t       ctrl_q, ctrl_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             feed_now;
  logic             wr_ctrl, wr_feed;
  logic [N_STAGE-1:0] reached;
  logic [N_STAGE-1:0] done_q;
  logic [N_STAGE-1:0] fire;
  logic [N_STAGE-1:0] stage_en;
  logic [3:0]       stage_code [N_STAGE];
  logic             irq_q, rst_req_q;
  logic [31:0]      rdata_q;

  assign wr_ctrl = reg_we && (reg_addr == CTRL_OFF);
  assign wr_feed = reg_we && (reg_addr == FEED_OFF);

  wdog_feed_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_feed),
    .wr_byte (reg_wdata[7:0]),
    .feed_o  (feed_now)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (ctrl_q.wd_en),
    .clear (feed_now || !ctrl_q.wd_en),
    .cnt_o (cnt_q)
  );

  assign stage_code[0] = ctrl_q.int_code;
  assign stage_code[1] = ctrl_q.rst_code;
  assign stage_en[0]   = ctrl_q.int_en;
  assign stage_en[1]   = ctrl_q.rst_en;

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    wdog_limit_cmp #(.CNT_W(CNT_W), .EXP_SHIFT(EXP_SHIFT)) u_cmp (
      .cnt     (cnt_q),
      .code    (stage_code[s]),
      .reached (reached[s])
    );

    assign fire[s] = ctrl_q.wd_en && stage_en[s] && reached[s] &&
                     !done_q[s] && !feed_now;

    always_ff @(posedge clk) begin
      if (rst || !ctrl_q.wd_en || feed_now) begin
        done_q[s] <= 1'b0;
      end else if (fire[s]) begin
        done_q[s] <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_ctrl) begin
      ctrl_nxt.int_code = reg_wdata[INT_CODE_LSB +: 4];
      ctrl_nxt.rst_code = reg_wdata[RST_CODE_LSB +: 4];
      ctrl_nxt.wd_en    = reg_wdata[EN_BIT];
      ctrl_nxt.int_en   = reg_wdata[IEN_BIT];
      ctrl_nxt.rst_en   = reg_wdata[REN_BIT];
      if (!reg_wdata[PEND_BIT]) ctrl_nxt.int_pend = 1'b0;
      if (!reg_wdata[FLAG_BIT]) ctrl_nxt.rst_flag = 1'b0;
    end
    if (fire[0]) ctrl_nxt.int_pend = 1'b1;
    if (fire[1]) ctrl_nxt.rst_flag = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      ctrl_q    <= ctrl_nxt;
      irq_q     <= ctrl_nxt.int_pend && ctrl_nxt.int_en;
      rst_req_q <= fire[1];
      rdata_q   <= (reg_addr == CTRL_OFF) ? ctrl_to_word(ctrl_q) : '0;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int CNT_W = 32
) (
  input logic                clk,
  input logic                rst,
  input wdog_pkg::wdog_ctrl_t ctrl,
  input logic [CNT_W-1:0]    cnt,
  input logic                feed,
  input logic                irq,
  input logic                rst_req
);
  // R3
  rst_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R7
  rst_req_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> ctrl.rst_flag);

  // R7
  rst_req_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(ctrl.rst_en && ctrl.wd_en));

  // R4
  disabled_holds_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.wd_en |=> (cnt == '0));

  // R5
  irq_matches_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (ctrl.int_pend && ctrl.int_en));

  // R5
  pend_rise_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl.int_pend) |-> $past(ctrl.int_en && ctrl.wd_en));

  // R8
  feed_clears_count_chk: assert property (@(posedge clk) disable iff (rst)
    feed |=> (cnt == '0));
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ctrl    (ctrl_q),
  .cnt     (cnt_q),
  .feed    (feed_now),
  .irq     (irq_o),
  .rst_req (rst_req_o)
);

// File: tb/wdog_two_stage_test.sv
module wdog_two_stage_test;
  localparam int SHIFT = 10;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_o, rst_req_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  wdog_two_stage #(.ADDR_W(AW), .EXP_SHIFT(SHIFT)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  function automatic int tmo(int code);
    return 1 << (31 - code - SHIFT);
  endfunction

  // Control word: bits 9 and 31 are written as 1 (no clear) unless requested
  function automatic logic [31:0] cw(bit en, bit ien, bit ren, int icode, int rcode,
                                     bit keep_pend = 1, bit keep_flag = 1);
    logic [31:0] w = '0;
    w[3:0] = icode[3:0]; w[7:4] = rcode[3:0];
    w[8] = en; w[10] = ien; w[11] = ren; w[9] = keep_pend; w[31] = keep_flag;
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; reg_we = 1'b0; reg_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1 reg_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(posedge clk); #1 d = reg_rdata;
  endtask

  task automatic edges(int n);
    repeat (n) begin @(posedge clk); end
    #1;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    check("R1 irq", irq_o, 0);
    check("R1 rst_req", rst_req_o, 0);
    rd(0, d);
    check("R1 ctrl", d, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    do_reset();
    wr(0, cw(0, 1, 1, 15, 15));
    edges(300);
    check("R4 irq while disabled", irq_o, 0);
    rd(0, d);
    check("R4 flags while disabled", {d[31], d[9]}, 0);
  endtask

  task automatic t_irq_timing(int code);
    logic [31:0] d;
    do_reset();
    wr(0, cw(1, 1, 0, code, 12));
    edges(tmo(code));
    check($sformatf("R2 irq before T code %0d", code), irq_o, 0);
    edges(1);
    check($sformatf("R2 irq at T+1 code %0d", code), irq_o, 1);
    rd(0, d);
    check("R2 pending bit 9", d[9], 1);
  endtask

  task automatic t_clear_pending();
    logic [31:0] d;
    do_reset();
    wr(0, cw(1, 1, 0, 15, 12));
    edges(tmo(15) + 2);
    wr(0, cw(1, 1, 0, 15, 12, 0, 1));
    check("R6 irq cleared", irq_o, 0);
    edges(20);
    check("R6 stays clear until restart", irq_o, 0);
    rd(0, d);
    check("R6 pending bit 9 cleared", d[9], 0);
  endtask

  task automatic t_irq_masked();
    logic [31:0] d;
    do_reset();
    wr(0, cw(1, 0, 0, 15, 12));
    edges(tmo(15) + 20);
    check("R5 irq masked", irq_o, 0);
    rd(0, d);
    check("R5 pending not set when disabled", d[9], 0);
  endtask

  task automatic t_reset_pulse();
    logic [31:0] d;
    int pulses;
    do_reset();
    wr(0, cw(1, 0, 1, 15, 14));
    edges(tmo(14));
    check("R3 no pulse before Tr", rst_req_o, 0);
    edges(1);
    check("R3 pulse at Tr+1", rst_req_o, 1);
    pulses = 0;
    for (int i = 0; i < 200; i++) begin
      edges(1);
      if (rst_req_o) pulses++;
    end
    check("R3 single pulse", pulses, 0);
    rd(0, d);
    check("R7 flag set", d[31], 1);
    wr(0, cw(1, 0, 1, 15, 14, 1, 1));
    rd(0, d);
    check("R7 writing 1 keeps flag", d[31], 1);
    wr(0, cw(1, 0, 1, 15, 14, 1, 0));
    rd(0, d);
    check("R7 writing 0 clears flag", d[31], 0);
    wr(0, cw(1, 0, 1, 15, 14, 1, 1));
    rd(0, d);
    check("R7 writing 1 does not set", d[31], 0);
  endtask

  task automatic t_reset_disabled();
    logic [31:0] d;
    int pulses = 0;
    do_reset();
    wr(0, cw(1, 0, 0, 15, 15));
    for (int i = 0; i < 150; i++) begin
      edges(1);
      if (rst_req_o) pulses++;
    end
    check("R7 no pulse with bit 11 clear", pulses, 0);
    rd(0, d);
    check("R7 flag stays 0", d[31], 0);
  endtask

  task automatic t_feed_ok();
    do_reset();
    wr(0, cw(1, 1, 0, 15, 12));
    edges(50);
    wr(4, 32'hA5);
    wr(4, 32'h5A);
    edges(tmo(15));
    check("R8 no irq T after feed", irq_o, 0);
    edges(1);
    check("R8 irq T+1 after feed", irq_o, 1);
  endtask

  task automatic t_feed_broken();
    do_reset();
    wr(0, cw(1, 1, 0, 15, 12));
    edges(40);
    wr(4, 32'hA5);
    wr(4, 32'h33);
    wr(4, 32'h5A);
    edges(tmo(15) - 43);
    check("R9 broken seq: no irq yet", irq_o, 0);
    edges(1);
    check("R9 broken seq ignored", irq_o, 1);
  endtask

  task automatic t_feed_restart();
    do_reset();
    wr(0, cw(1, 1, 0, 15, 12));
    edges(40);
    wr(4, 32'hA5);
    wr(4, 32'hA5);
    wr(4, 32'h5A);
    edges(tmo(15));
    check("R9 A5 A5 5A feeds: no irq", irq_o, 0);
    edges(1);
    check("R9 A5 A5 5A feeds: irq", irq_o, 1);
  endtask

  task automatic t_read_map();
    logic [31:0] d;
    do_reset();
    wr(0, cw(0, 1, 1, 3, 9));
    rd(0, d);
    check("R10 ctrl readback", d, 32'h00000C93);
    rd(4, d);
    check("R10 feed reads 0", d, 0);
    rd(8, d);
    check("R10 other offset reads 0", d, 0);
  endtask

  initial begin
    edges(150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_disabled();
    t_irq_timing(15);
    t_irq_timing(14);
    t_irq_timing(13);
    t_clear_pending();
    t_irq_masked();
    t_reset_pulse();
    t_reset_disabled();
    t_feed_ok();
    t_feed_broken();
    t_feed_restart();
    t_read_map();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule